// File: doc/BRIEF.md
# Quadrature Encoder Counter Channel

This block counts motion from a single incremental encoder. It takes three logic-level inputs: two phase signals A and B, and an index pulse. Each input passes through a two-flop synchronizer. A digital deglitch stage can then be switched in. After that, the phases are decoded in one of two ways:
- as quadrature with four counts per cycle, or
- as a clock/direction pair, where chosen edges of A step the count and the level of B selects the direction.

A 32-bit signed-agnostic register holds the position. It wraps modulo 2^32.

The index input has three roles. It can gate counting by its level. It can clear the position by its level or on a selected edge. Its current deglitched level is also available as a status output.

All control fields are plain inputs. A surrounding register block is expected to drive them.

Top module: `qenc_channel`

## Requirements
- R1: While `rst_n` is low and after it is released, `count` is 0 and `idx_level` is 0.
- R2: With `dec_mode`=00, each single-phase step of the Gray sequence AB = 00→10→11→01→00 (A leads B) adds one to `count`, including steps spaced two clocks apart.
- R3: With `dec_mode`=00, each step of the reverse sequence subtracts one. The count wraps from 0 to 32'hFFFF_FFFF and back.
- R4: With `dec_mode`=00, a transition in which A and B change in the same clock leaves `count` unchanged.
- R5: With `dec_mode`=01, 10 or 11, `count` steps on the rising, falling or either edge of A respectively. It counts up when B is 1 and down when B is 0. B changes alone never step the count.
- R6: `gate_sel`=00 always allows counting; 01 never does; 10 allows it only while the index is 0; 11 allows it only while the index is 1.
- R7: `clr_sel`=001 holds `count` at 0. 010 clears while the index is 0. 011 clears while the index is 1.
- R8: `clr_sel`=100, 101 and 110 clear `count` on the rising, falling or either edge of the index. 000 and 111 never clear.
- R9: A clear takes priority over a count step in the same clock.
- R10: With `filt_en`=1, a level on A, B or the index is accepted only after it has been stable for 16 consecutive clocks. Shorter pulses have no effect.
- R11: `idx_level` follows the synchronized (and, when enabled, filtered) level of the index input.
- R12: From one clock to the next, `count` either stays the same, moves by exactly one, or becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index |
| dec_mode | input | 2 | 00 quadrature x4; 01/10/11 clock/direction on A rise/fall/either |
| gate_sel | input | 2 | Count permission: always, never, index low, index high |
| clr_sel | input | 3 | Clear source: off, hold, index level, or index edge |
| filt_en | input | 1 | Enables the 16-clock deglitch stage |
| count | output | 32 | Position value |
| idx_level | output | 1 | Current index level after conditioning |

## Verification
The assertions assume that the control fields are static around the edges they describe. They also assume that, in quadrature mode, only one phase moves between successive conditioned samples unless a double change is deliberately applied. The stimulus changes a control field only while A, B and the index are quiet. Between steps it holds every input for at least the synchronizer and filter latency. The only simultaneous A/B change it produces is the one that checks R4.

// File: rtl/qenc_channel.sv
module qenc_channel #(
  parameter int CNT_W    = 32,
  parameter int FILT_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic [1:0]       dec_mode,
  input  logic [1:0]       gate_sel,
  input  logic [2:0]       clr_sel,
  input  logic             filt_en,
  output logic [CNT_W-1:0] count,
  output logic             idx_level
);
  localparam int FW  = $clog2(FILT_LEN + 1);
  localparam int NIN = 3;

  logic [NIN-1:0] sy1, sy2, flt, prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      prv <= '0;
    end else begin
      sy1 <= {enc_idx, enc_b, enc_a};
      sy2 <= sy1;
      prv <= flt;
    end
  end

  for (genvar g = 0; g < NIN; g++) begin : g_flt
    logic          lvl_q;
    logic [FW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
        run_q <= '0;
      end else if (!filt_en) begin
        lvl_q <= sy2[g];
        run_q <= '0;
      end else if (sy2[g] == lvl_q) begin
        run_q <= '0;
      end else if (run_q == FW'(FILT_LEN - 1)) begin
        lvl_q <= sy2[g];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
    assign flt[g] = lvl_q;
  end

  wire a  = flt[0], b  = flt[1], ix = flt[2];
  wire pa = prv[0], pb = prv[1], pi = prv[2];
  wire a_chg = a ^ pa;
  wire b_chg = b ^ pb;

  logic step, up, gate_ok, clr_now;

  always_comb begin
    unique case (dec_mode)
      2'b00: begin step = a_chg ^ b_chg; up = a ^ pb; end
      2'b01: begin step = a & ~pa;       up = b;      end
      2'b10: begin step = ~a & pa;       up = b;      end
      default: begin step = a_chg;       up = b;      end
    endcase
  end

  always_comb begin
    unique case (gate_sel)
      2'b00: gate_ok = 1'b1;
      2'b01: gate_ok = 1'b0;
      2'b10: gate_ok = ~ix;
      default: gate_ok = ix;
    endcase
  end

  always_comb begin
    case (clr_sel)
      3'b001:  clr_now = 1'b1;
      3'b010:  clr_now = ~ix;
      3'b011:  clr_now = ix;
      3'b100:  clr_now = ix & ~pi;
      3'b101:  clr_now = ~ix & pi;
      3'b110:  clr_now = ix ^ pi;
      default: clr_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= '0;
    else if (clr_now)          count <= '0;
    else if (step && gate_ok)  count <= up ? count + 1'b1 : count - 1'b1;
  end

  assign idx_level = ix;

  a_r12_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1) ||
    (count == $past(count) - 1'b1) || (count == '0));

  a_r7_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == 3'b001) |=> (count == '0));

  a_r6_never_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_sel == 2'b01 && clr_sel == 3'b000) |=> $stable(count));

  a_r4_double_change: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode == 2'b00 && a_chg && b_chg && clr_sel == 3'b000) |=> $stable(count));

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sel == 3'b010 && !ix) |=> (count == '0));
endmodule

// File: tb/qenc_channel_tb.sv
module qenc_channel_tb;
  localparam int CLK_PERIOD = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enc_a = 0, enc_b = 0, enc_idx = 0, filt_en = 0;
  logic [1:0] dec_mode = 2'b00, gate_sel = 2'b00;
  logic [2:0] clr_sel = 3'b000;
  logic [31:0] count;
  logic idx_level;

  qenc_channel u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .dec_mode(dec_mode), .gate_sel(gate_sel), .clr_sel(clr_sel), .filt_en(filt_en),
    .count(count), .idx_level(idx_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [31:0] val; bit is_idx; string tag; } item_t;
  item_t exp_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] e = 0;
  int pos = 0;
  logic [1:0] gray [4] = '{2'b00, 2'b10, 2'b11, 2'b01};

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = exp_q.pop_front();
      act = it.is_idx ? {31'b0, idx_level} : count;
      n_run++;
      if (act !== it.val) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.val);
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] v, input string tag);
    item_t it;
    it.val = v; it.is_idx = 0; it.tag = tag;
    exp_q.push_back(it);
    settle(2);
  endtask

  task automatic chk_idx(input logic v, input string tag);
    item_t it;
    it.val = {31'b0, v}; it.is_idx = 1; it.tag = tag;
    exp_q.push_back(it);
    settle(2);
  endtask

  task automatic qstep(input int d, input int hold);
    pos = (((pos + d) % 4) + 4) % 4;
    {enc_a, enc_b} = gray[pos];
    settle(hold);
  endtask

  task automatic pulse_a(input int hold);
    enc_a = 1; settle(hold);
    enc_a = 0; settle(hold);
  endtask

  task automatic set_idx(input logic v);
    enc_idx = v; settle(6);
  endtask

  initial begin
    settle(3);
    chk(0, "R1 count in reset");
    rst_n = 1; settle(4);
    chk(0, "R1 count after reset");
    chk_idx(0, "R11 idx after reset");

    for (int k = 0; k < 8; k++) qstep(1, 6);
    e = 8; chk(e, "R2 forward x4");
    for (int k = 0; k < 4; k++) qstep(1, 2);
    settle(6); e = 12; chk(e, "R2 fast forward");
    for (int k = 0; k < 13; k++) qstep(-1, 6);
    e = 32'hFFFF_FFFF; chk(e, "R3 reverse with wrap");
    qstep(2, 6); chk(e, "R4 double change");
    qstep(2, 6); chk(e, "R4 second double change");
    qstep(1, 6); e = 0; chk(e, "R3 wrap back to 0");

    dec_mode = 2'b01; settle(2);
    enc_b = 1; settle(6); chk(e, "R5 B alone no step");
    for (int k = 0; k < 3; k++) pulse_a(6);
    e = 3; chk(e, "R5 rising up");
    dec_mode = 2'b10; enc_b = 0; settle(6);
    for (int k = 0; k < 2; k++) pulse_a(6);
    e = 1; chk(e, "R5 falling down");
    dec_mode = 2'b11; enc_b = 1; settle(6);
    pulse_a(6); e = 3; chk(e, "R5 either edge");

    dec_mode = 2'b01;
    gate_sel = 2'b01; settle(2);
    pulse_a(6); pulse_a(6); chk(e, "R6 never");
    gate_sel = 2'b10; set_idx(1);
    pulse_a(6); chk(e, "R6 idx-low gate blocked");
    set_idx(0); pulse_a(6); e = 4; chk(e, "R6 idx-low gate open");
    gate_sel = 2'b11; set_idx(1);
    pulse_a(6); e = 5; chk(e, "R6 idx-high gate open");
    set_idx(0); pulse_a(6); chk(e, "R6 idx-high gate blocked");
    gate_sel = 2'b00; settle(2);

    chk_idx(0, "R11 idx low");
    set_idx(1); chk_idx(1, "R11 idx high");

    clr_sel = 3'b001; settle(4); e = 0; chk(e, "R7 hold clear");
    pulse_a(6); chk(e, "R7 hold blocks count");
    clr_sel = 3'b010; settle(2);
    pulse_a(6); pulse_a(6); e = 2; chk(e, "R7 idx-low clear inactive");
    set_idx(0); e = 0; chk(e, "R7 idx-low clear");
    pulse_a(6); chk(e, "R9 clear over count");
    set_idx(1); pulse_a(6); e = 1; chk(e, "R7 counts with idx high");
    clr_sel = 3'b011; settle(4); e = 0; chk(e, "R7 idx-high clear");

    clr_sel = 3'b100; settle(2);
    pulse_a(6); pulse_a(6); e = 2; chk(e, "R8 rise mode counting");
    set_idx(0); chk(e, "R8 fall ignored in rise mode");
    set_idx(1); e = 0; chk(e, "R8 rise clears");
    pulse_a(6); e = 1;
    clr_sel = 3'b101; settle(2);
    set_idx(0); e = 0; chk(e, "R8 fall clears");
    pulse_a(6); pulse_a(6); e = 2;
    clr_sel = 3'b110; settle(2);
    set_idx(1); e = 0; chk(e, "R8 either rise clears");
    pulse_a(6); e = 1;
    set_idx(0); e = 0; chk(e, "R8 either fall clears");
    clr_sel = 3'b111; settle(2);
    pulse_a(6); pulse_a(6); e = 2;
    set_idx(1); set_idx(0); chk(e, "R8 reserved no clear");
    clr_sel = 3'b000; settle(2);

    filt_en = 1; settle(4);
    enc_a = 1; settle(8); enc_a = 0; settle(30);
    chk(e, "R10 short A pulse rejected");
    pulse_a(25); e = 3; chk(e, "R10 long A pulse accepted");
    enc_idx = 1; settle(8); enc_idx = 0; settle(30);
    chk_idx(0, "R10 short idx pulse rejected");
    enc_idx = 1; settle(25); chk_idx(1, "R10 long idx accepted");
    enc_idx = 0; settle(25); chk_idx(0, "R11 idx back low");

    settle(4);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule